// File: doc/BRIEF.md
# RS-485 Driver-Enable Turnaround Controller

This block produces the direction (driver-enable) signal for a UART transmitter on a half-duplex RS-485 bus. The line driver is enabled as soon as the transmitter reports that it has data. After the final stop bit has left the shifter, the driver stays enabled for a programmable number of bit periods, from 0 to 255. Only then does the block release the bus so that other nodes may answer.

The block sits beside the UART. It takes a one-cycle bit-period strobe from the baud generator, a level flag that is high while transmit data is pending, and a one-cycle pulse at the end of each stop bit. Three configuration inputs select whether automatic control is on, which level means "driving", and the length of the turnaround delay. One clock and a synchronous active-high reset are used, and the output is registered.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: In the first cycle after reset, `dir_out` is 1. This is the inactive level for the reset polarity of 0.
- R2: While `cfg_en` is 0, the clock edge drives `dir_out` to the inactive level (the inverse of `cfg_pol`). Any countdown in progress is discarded, and stop pulses and ticks have no effect.
- R3: When `cfg_en` and `tx_busy` are both 1 at a clock edge, `dir_out` shows the active level (equal to `cfg_pol`) after that edge.
- R4: A `stop_done` pulse with `tx_busy` low and a nonzero delay D starts a countdown. `dir_out` stays active through the first D-1 `bit_tick` strobes and goes inactive on the edge that samples the D-th strobe. A tick in the same cycle as the stop pulse is not counted.
- R5: With a delay of 0, `dir_out` goes inactive on the edge that samples the `stop_done` pulse.
- R6: If `tx_busy` returns during a countdown, the countdown is dropped and `dir_out` stays active. Ticks then have no effect until the next `stop_done` pulse starts a new full countdown.
- R7: `cfg_delay` is captured when a countdown starts. Changing it during the countdown does not shorten or lengthen that countdown.
- R8: With `cfg_pol` = 1 the levels are swapped: 1 means driving and 0 means released. With `cfg_pol` = 0, 0 means driving and 1 means released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Automatic direction control enable |
| cfg_pol | input | 1 | Active level of `dir_out` while driving |
| cfg_delay | input | DLY_W (8) | Turnaround length in bit periods |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| tx_busy | input | 1 | Transmitter has data to send |
| stop_done | input | 1 | One-cycle pulse at the end of a stop bit |
| dir_out | output | 1 | Driver-enable / direction output |

## Verification
The embedded properties check the disabled level, the driving level while data is pending, the zero-delay release, the return to sending when data reappears mid-countdown, and that the counter is never decremented at zero. These are checked on every cycle. The exact release edge for each delay and tick spacing, the capture of the delay at countdown start, and the behaviour after a re-enable can only be shown by the bench's swept scenarios, which count ticks and compare against the programmed value.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_turn_cnt.sv
module rs485_turn_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= cnt_q - ONE;
  end

  assign cnt_last = (cnt_q == ONE);

  // R4
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tx_busy,
  input  logic       stop_done,
  input  logic       bit_tick,
  input  logic       dly_zero,
  input  logic       cnt_last,
  output dir_state_e state_q,
  output logic       cnt_load,
  output logic       cnt_dec,
  output logic       cnt_clr,
  output logic       drive_next
);
  dir_state_e nxt;

  always_comb begin
    nxt      = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_clr  = 1'b0;
    if (!en) begin
      nxt     = ST_IDLE;
      cnt_clr = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (tx_busy) nxt = ST_SEND;
        ST_SEND: begin
          if (stop_done && !tx_busy) begin
            if (dly_zero) nxt = ST_IDLE;
            else begin
              nxt      = ST_HOLD;
              cnt_load = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tx_busy) begin
            nxt     = ST_SEND;
            cnt_clr = 1'b1;
          end else if (bit_tick) begin
            cnt_dec = 1'b1;
            if (cnt_last) nxt = ST_IDLE;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign drive_next = (nxt != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= nxt;
  end
endmodule

// File: rtl/rs485_dir_drv.sv
module rs485_dir_drv (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic drive_next,
  output logic dir_out
);
  always_ff @(posedge clk) begin
    if (rst)             dir_out <= 1'b1;
    else if (drive_next) dir_out <= pol;
    else                 dir_out <= ~pol;
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_pol,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             stop_done,
  output logic             dir_out
);
  dir_state_e state_q;
  logic cnt_load, cnt_dec, cnt_clr, cnt_last, drive_next;
  logic dly_zero;

  assign dly_zero = (cfg_delay == '0);

  rs485_dir_fsm fsm_i (
    .clk(clk), .rst(rst), .en(cfg_en), .tx_busy(tx_busy),
    .stop_done(stop_done), .bit_tick(bit_tick), .dly_zero(dly_zero),
    .cnt_last(cnt_last), .state_q(state_q), .cnt_load(cnt_load),
    .cnt_dec(cnt_dec), .cnt_clr(cnt_clr), .drive_next(drive_next)
  );

  rs485_turn_cnt #(.W(DLY_W)) cnt_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .load(cnt_load),
    .load_val(cfg_delay), .dec(cnt_dec), .cnt_last(cnt_last)
  );

  rs485_dir_drv drv_i (
    .clk(clk), .rst(rst), .pol(cfg_pol),
    .drive_next(drive_next), .dir_out(dir_out)
  );

  // R2
  off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (dir_out == !$past(cfg_pol)));

  // R3
  send_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && tx_busy) |=> (dir_out == $past(cfg_pol)));

  // R5
  zero_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && state_q == ST_SEND && stop_done && !tx_busy && dly_zero)
      |=> (dir_out == !$past(cfg_pol)));

  // R6
  abandon_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && state_q == ST_HOLD && tx_busy) |=> (state_q == ST_SEND));
endmodule

// File: tb/rs485_dir_ctrl_tb_top.sv
module rs485_dir_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, cfg_en, cfg_pol, bit_tick, tx_busy, stop_done;
  logic [7:0] cfg_delay;
  logic dir_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
    .cfg_delay(cfg_delay), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .stop_done(stop_done), .dir_out(dir_out)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (dir_out !== exp) begin
      errors++;
      $display("FAIL %s dir_out=%b expected=%b at %0t", req, dir_out, exp, $time);
    end
  endtask

  // one cycle: stimulus applied at negedge, result visible at the next negedge
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    bit_tick = 0; tx_busy = 0; stop_done = 0;
  endtask

  // send: busy for n cycles, then a final stop pulse with busy low
  task automatic send_frame(input int n, input logic pol, input string req);
    tx_busy = 1;
    for (int i = 0; i < n; i++) begin
      cyc();
      chk(req, pol);
    end
    tx_busy = 0; stop_done = 1;
    cyc();
    stop_done = 0;
  endtask

  // issue k ticks spaced sp cycles apart; check level after each cycle
  task automatic ticks(input int k, input int sp, input int release_at,
                       input logic pol, input string req);
    for (int t = 1; t <= k; t++) begin
      for (int g = 0; g < sp - 1; g++) begin
        cyc();
        chk(req, (release_at > 0 && t > release_at) ? ~pol : pol);
      end
      bit_tick = 1;
      cyc();
      bit_tick = 0;
      chk(req, (release_at > 0 && t >= release_at) ? ~pol : pol);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; cfg_en = 0; cfg_pol = 0; cfg_delay = 0;
    idle_inputs();
    cyc(); cyc();
    rst = 0;
    chk("R1", 1'b1);
    cyc();
    chk("R1", 1'b1);

    // sweep polarity, delay and tick spacing (R4 R5 R8)
    cfg_en = 1;
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 8; d++) begin
        for (int sp = 1; sp <= 3; sp++) begin
          cfg_pol = p[0]; cfg_delay = 8'(d);
          cyc();
          chk("R8", ~cfg_pol);
          send_frame(2, cfg_pol, "R3");
          if (d == 0) chk("R5", ~cfg_pol);
          else begin
            chk("R4", cfg_pol);
            ticks(d, sp, d, cfg_pol, "R4");
          end
          ticks(2, 1, 0, ~cfg_pol, "R4");
        end
      end
    end

    // full-range delay
    cfg_pol = 0; cfg_delay = 8'd255;
    send_frame(1, 1'b0, "R3");
    ticks(255, 1, 255, 1'b0, "R4");

    // stop pulse with busy still high keeps driving; tick with stop ignored
    cfg_delay = 8'd2;
    tx_busy = 1; cyc();
    stop_done = 1; cyc(); stop_done = 0;
    chk("R4", 1'b0);
    tx_busy = 0; stop_done = 1; bit_tick = 1; cyc();
    stop_done = 0; bit_tick = 0;
    chk("R4", 1'b0);
    ticks(2, 1, 2, 1'b0, "R4");

    // abandon countdown (R6)
    cfg_delay = 8'd5;
    send_frame(1, 1'b0, "R6");
    ticks(3, 1, 0, 1'b0, "R6");
    tx_busy = 1; cyc(); chk("R6", 1'b0);
    tx_busy = 0;
    ticks(7, 1, 0, 1'b0, "R6");
    stop_done = 1; cyc(); stop_done = 0;
    ticks(5, 2, 5, 1'b0, "R6");

    // capture at start (R7)
    cfg_delay = 8'd4;
    send_frame(1, 1'b0, "R7");
    ticks(1, 1, 0, 1'b0, "R7");
    cfg_delay = 8'd1;
    ticks(3, 1, 3, 1'b0, "R7");
    cfg_delay = 8'd2;
    send_frame(1, 1'b0, "R7");
    cfg_delay = 8'd9;
    ticks(2, 1, 2, 1'b0, "R7");

    // disable mid-countdown and while busy (R2)
    cfg_delay = 8'd6;
    send_frame(1, 1'b0, "R2");
    ticks(2, 1, 0, 1'b0, "R2");
    cfg_en = 0; cyc(); chk("R2", 1'b1);
    tx_busy = 1; cyc(); chk("R2", 1'b1);
    cfg_pol = 1; cyc(); chk("R2", 1'b0);
    cfg_pol = 0; tx_busy = 0; stop_done = 1; cyc(); stop_done = 0;
    chk("R2", 1'b1);
    cfg_en = 1;
    ticks(8, 1, 0, 1'b1, "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule